// File: doc/BRIEF.md
# Mode-Configurable Serial Shift Register

This block is a byte-wide serial shifter with a three-bit mode field. The field picks the direction and the source of the shift clock. In the input direction, the block takes bits from a serial data line into bit 0 and moves the contents toward the MSB. In the output direction, it presents the MSB on the serial data line and rotates the byte, so the contents recirculate. The shift clock can come from a timer tick, from the system clock, or from an external clock line. When the block makes the clock itself, it drives that clock onto the clock pin. The pin idles high.

Software loads the shifter in parallel with a write strobe and reads its contents back at any time. In every mode except disabled and free-running, a bit counter stops the transfer after eight shifts and raises a completion flag. A read strobe or a write strobe clears the flag and starts a new transfer. The timer that makes the tick and the interrupt logic that collects the flag are outside the block.

Top module: `sreg_top`

## Requirements
- R1: After reset, rdata_o is 0, done_o is 0, sclk_o is 1, and neither the clock pin nor the data pin is driven while mode_i is 000.
- R2: A cycle with wr_i high loads wdata_i into the shifter, and rdata_o shows the loaded value from the next cycle on.
- R3: In modes 001, 010 and 011, each shift happens on a falling edge of the shift clock. The contents move one place toward the MSB and bit 0 takes sdata_i. Eight shifts leave the received bits in rdata_o, first bit in bit 7.
- R4: In modes 101, 110 and 111, each shift happens on a rising edge of the shift clock. sdata_o carries the current bit 7, and each shift rotates the byte left by one. After k shifts rdata_o is the loaded value rotated left by k, so eight shifts restore it.
- R5: Mode bits [1:0] select the clock source. 01, and the mode 100, toggle the generated clock once per tick_i. 10 toggles it every system clock cycle. In those modes sclk_oe_o is 1. 11 uses sclk_i through a two-flop synchronizer with sclk_oe_o at 0. sclk_o is high whenever the block does not drive it.
- R6: In every mode except 000 and 100, the eighth shift raises done_o and stops the transfer. Further clock edges shift nothing, and a generated clock returns high and stays there.
- R7: A cycle with rd_i or wr_i high clears done_o in the next cycle and restarts the count at zero.
- R8: Mode 100 shifts out circularly at the tick rate without stopping and never raises done_o.
- R9: Mode 000 shifts nothing and drives neither pin, whatever tick_i and sclk_i do.
- R10: sdata_oe_o equals mode_i[2]. sdata_o comes from a holding register and changes only on a load or a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Mode field: bit 2 is the direction, bits [1:0] are the clock source |
| wr_i | input | 1 | Parallel load strobe |
| rd_i | input | 1 | Readback strobe; clears the flag and restarts the count |
| wdata_i | input | WIDTH | Parallel load data |
| rdata_o | output | WIDTH | Current shifter contents |
| tick_i | input | 1 | Timer tick, one cycle wide |
| sclk_i | input | 1 | External shift clock (asynchronous) |
| sclk_o | output | 1 | Generated shift clock |
| sclk_oe_o | output | 1 | Drive enable for the shift clock pin |
| sdata_i | input | 1 | Serial data in |
| sdata_o | output | 1 | Serial data out from the holding register |
| sdata_oe_o | output | 1 | Drive enable for the serial data pin |
| done_o | output | 1 | Eight-bit transfer complete |

## Verification
The bench builds the block with WIDTH at 8 and SYNC_STAGES at 2. With these values a full transfer takes only a few dozen cycles at most, so the sweep covers all eight modes for several load values and serial patterns. The serial stream, the length of each clock half-period and the point where the counter stops are checked against arithmetic rotations. The two-stage synchronizer keeps the latency from an external edge to the shift short enough for the bench to drive the external clock directly with a few cycles per phase.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [2:0] {
        MODE_OFF      = 3'b000,
        MODE_IN_TMR   = 3'b001,
        MODE_IN_SYS   = 3'b010,
        MODE_IN_EXT   = 3'b011,
        MODE_OUT_FREE = 3'b100,
        MODE_OUT_TMR  = 3'b101,
        MODE_OUT_SYS  = 3'b110,
        MODE_OUT_EXT  = 3'b111
    } sreg_mode_e;

    function automatic logic mode_is_out(input logic [2:0] m);
        return m[2];
    endfunction

    function automatic logic mode_is_free(input logic [2:0] m);
        return m == MODE_OUT_FREE;
    endfunction

    function automatic logic mode_is_ext(input logic [2:0] m);
        return m[1:0] == 2'b11;
    endfunction

    function automatic logic mode_is_internal(input logic [2:0] m);
        return (m != MODE_OFF) && !mode_is_ext(m);
    endfunction

    function automatic logic mode_uses_tick(input logic [2:0] m);
        return (m[1:0] == 2'b01) || mode_is_free(m);
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = async_i;
        end else begin : g_rest
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sreg_clkgen.sv
module sreg_clkgen
    import sreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       ext_clk_i,
    output logic       shift_o,
    output logic       sclk_o,
    output logic       sclk_oe_o
);
    typedef struct packed {
        logic gen;
        logic ext_prev;
    } clk_state_t;

    clk_state_t st_d, st_q;

    always_comb begin
        logic rate_evt;
        logic out_dir;
        st_d     = st_q;
        shift_o  = 1'b0;
        out_dir  = mode_is_out(mode_i);
        rate_evt = mode_uses_tick(mode_i) ? tick_i : 1'b1;
        st_d.ext_prev = ext_clk_i;

        if (mode_is_internal(mode_i)) begin
            // Toggle while a transfer runs, or once more to park the clock high.
            if (rate_evt && (run_i || !st_q.gen)) begin
                st_d.gen = !st_q.gen;
                shift_o  = run_i && (out_dir ? !st_q.gen : st_q.gen);
            end
        end else begin
            st_d.gen = 1'b1;
        end

        if (mode_is_ext(mode_i)) begin
            shift_o = run_i && (out_dir ? (!st_q.ext_prev && ext_clk_i)
                                        : (st_q.ext_prev && !ext_clk_i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{gen: 1'b1, ext_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign sclk_o    = st_q.gen;
    assign sclk_oe_o = mode_is_internal(mode_i);
endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath
    import sreg_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             shift_i,
    input  logic             sdata_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             sdata_o,
    output logic             done_o,
    output logic             run_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic [WIDTH-1:0] sr;
        logic             hold;
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             done;
    } dp_state_t;

    dp_state_t st_d, st_q;

    always_comb begin
        logic new_bit;
        st_d    = st_q;
        new_bit = mode_is_out(mode_i) ? st_q.hold : sdata_i;

        if (wr_i) begin
            st_d.sr   = wdata_i;
            st_d.hold = wdata_i[WIDTH-1];
        end else if (shift_i) begin
            st_d.sr   = {st_q.sr[WIDTH-2:0], new_bit};
            st_d.hold = st_q.sr[WIDTH-2];
        end

        if (rd_i || wr_i) begin
            st_d.cnt    = '0;
            st_d.active = 1'b1;
            st_d.done   = 1'b0;
        end else if (shift_i && !mode_is_free(mode_i)) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt    = '0;
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.sr;
    assign sdata_o = st_q.hold;
    assign done_o  = st_q.done;
    assign run_o   = st_q.active || mode_is_free(mode_i);
endmodule

// File: rtl/sreg_top.sv
module sreg_top #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    input  logic             tick_i,
    input  logic             sclk_i,
    output logic             sclk_o,
    output logic             sclk_oe_o,
    input  logic             sdata_i,
    output logic             sdata_o,
    output logic             sdata_oe_o,
    output logic             done_o
);
    localparam int CNT_W = $clog2(WIDTH);

    logic ext_clk_sync;
    logic shift;
    logic run;

    sreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sclk_i),
        .sync_o  (ext_clk_sync)
    );

    sreg_clkgen u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .tick_i    (tick_i),
        .run_i     (run),
        .ext_clk_i (ext_clk_sync),
        .shift_o   (shift),
        .sclk_o    (sclk_o),
        .sclk_oe_o (sclk_oe_o)
    );

    sreg_datapath #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .shift_i (shift),
        .sdata_i (sdata_i),
        .rdata_o (rdata_o),
        .sdata_o (sdata_o),
        .done_o  (done_o),
        .run_o   (run)
    );

    assign sdata_oe_o = mode_i[2];
endmodule

// File: rtl/sreg_checker.sv
module sreg_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_i,
    input logic             wr_i,
    input logic             rd_i,
    input logic [WIDTH-1:0] wdata_i,
    input logic [WIDTH-1:0] rdata_o,
    input logic             sdata_i,
    input logic             sdata_o,
    input logic             sdata_oe_o,
    input logic             sclk_o,
    input logic             sclk_oe_o,
    input logic             done_o,
    input logic             shift
);
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> rdata_o == $past(wdata_i)); // R2

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !mode_i[2] && !wr_i)
        |=> rdata_o == {$past(rdata_o[WIDTH-2:0]), $past(sdata_i)}); // R3

    AST_ROTATE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && mode_i[2] && !wr_i)
        |=> rdata_o == {$past(rdata_o[WIDTH-2:0]), $past(rdata_o[WIDTH-1])}); // R4

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_oe_o |=> sclk_o); // R5

    AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_i != 3'b100 && !rd_i && !wr_i) |-> !shift); // R6

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i || wr_i) |=> !done_o); // R7

    AST_FREE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b100 && !done_o) |=> !done_o); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b000) |-> (!shift && !sclk_oe_o && !sdata_oe_o)); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !shift) |=> $stable(sdata_o)); // R10
endmodule

bind sreg_top sreg_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .sdata_i    (sdata_i),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .sclk_o     (sclk_o),
    .sclk_oe_o  (sclk_oe_o),
    .done_o     (done_o),
    .shift      (shift)
);

// File: tb/tb_sreg_top.sv
module tb_sreg_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_i = 3'b000;
    logic wr_i = 1'b0, rd_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] rdata_o;
    logic tick_i = 1'b0, sclk_i = 1'b1, sdata_i = 1'b0;
    logic sclk_o, sclk_oe_o, sdata_o, sdata_oe_o, done_o;

    always #5 clk = ~clk;

    sreg_top #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_i(wr_i), .rd_i(rd_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .sclk_i(sclk_i),
        .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .sdata_i(sdata_i),
        .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .done_o(done_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick_i <= (cyc % 3 == 0);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (mode %0d, cycle %0d)", req, act, exp, mode_i, cyc);
        end
    endtask

    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int k);
        int s = k % W;
        if (s == 0) return v;
        return (v << s) | (v >> (W - s));
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] v);
        wr_i = 1'b1; wdata_i = v;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic read_clear();
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        chk("R7 flag cleared by read", done_o, 0);
    endtask

    // Start from disabled mode so the generated clock is parked high.
    task automatic park_and_load(input logic [W-1:0] v);
        mode_i = 3'b000;
        step(3);
        load(v);
        chk("R2 parallel load", rdata_o, v);
    endtask

    task automatic run_internal(input logic [2:0] m, input logic [W-1:0] v, input logic [W-1:0] p);
        bit out_dir = m[2];
        bit free = (m == 3'b100);
        bit sys = (m[1:0] == 2'b10);
        logic prev = 1'b1;
        int edges = 0;
        int low_cycles = 0;
        park_and_load(v);
        sdata_i = p[W-1];
        mode_i = m;
        for (int c = 0; c < 110; c++) begin
            @(negedge clk);
            if (c == 0) chk("R5 internal clock driven", sclk_oe_o, 1);
            if (sclk_o == 1'b0) low_cycles++;
            if (prev == 1'b1 && sclk_o == 1'b0) begin
                if (out_dir) begin
                    if (free) chk("R8 free-running stream", sdata_o, v[W-1-(edges % W)]);
                    else      chk("R4 serial stream bit", sdata_o, v[W-1-edges]);
                end
                edges++;
            end
            if (!out_dir) sdata_i = (edges < W) ? p[W-1-edges] : ~p[0];
            prev = sclk_o;
        end
        if (free) begin
            chk("R8 keeps running", (edges > 12) ? 1 : 0, 1);
            chk("R8 never done", done_o, 0);
        end else begin
            chk("R6 shift count", edges, W);
            chk("R6 done raised", done_o, 1);
            chk("R6 clock parked high", sclk_o, 1);
            chk("R5 half-period length", low_cycles, W * (sys ? 1 : 3));
            if (out_dir) chk("R4 restored after full rotation", rdata_o, v);
            else         chk("R3 received byte", rdata_o, p);
        end
        chk("R10 data drive follows direction", sdata_oe_o, out_dir);
        read_clear();
    endtask

    task automatic run_ext_in(input logic [W-1:0] v, input logic [W-1:0] p);
        park_and_load(v);
        sclk_i = 1'b1;
        mode_i = 3'b011;
        step(3);
        chk("R5 external clock not driven", sclk_oe_o, 0);
        for (int k = 0; k < W + 2; k++) begin
            sdata_i = (k < W) ? p[W-1-k] : ~p[0];
            step(3);
            sclk_i = 1'b0; step(4);
            sclk_i = 1'b1; step(4);
            if (k == 2) chk("R3 partial shift-in", rdata_o, {v[W-4:0], p[W-1:W-3]});
        end
        chk("R3 received byte external", rdata_o, p);
        chk("R6 done external", done_o, 1);
        chk("R10 no data drive in input", sdata_oe_o, 0);
        read_clear();
    endtask

    task automatic run_ext_out(input logic [W-1:0] v);
        park_and_load(v);
        sclk_i = 1'b1;
        mode_i = 3'b111;
        step(3);
        for (int k = 0; k < W + 2; k++) begin
            sclk_i = 1'b0; step(4);
            if (k < W) chk("R4 serial stream external", sdata_o, v[W-1-k]);
            if (k == 3) chk("R4 partial rotation", rdata_o, rotl(v, 3));
            sclk_i = 1'b1; step(4);
        end
        chk("R6 stopped after eight", rdata_o, v);
        chk("R6 done external out", done_o, 1);
        chk("R10 data drive in output", sdata_oe_o, 1);
        read_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] vals [4] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset contents", rdata_o, 0);
        chk("R1 reset flag", done_o, 0);
        chk("R1 reset clock high", sclk_o, 1);
        chk("R1 reset clock undriven", sclk_oe_o, 0);
        chk("R1 reset data undriven", sdata_oe_o, 0);

        // Disabled mode ignores ticks and external clock.
        load(8'h96);
        for (int k = 0; k < 6; k++) begin
            sclk_i = 1'b0; step(4);
            sclk_i = 1'b1; step(4);
        end
        chk("R9 disabled no shift", rdata_o, 8'h96);
        chk("R9 disabled no clock drive", sclk_oe_o, 0);
        chk("R9 disabled no data drive", sdata_oe_o, 0);
        chk("R9 disabled no done", done_o, 0);

        foreach (vals[i]) begin
            logic [W-1:0] pat = vals[i] ^ 8'h5A ^ 8'(i * 37);
            run_internal(3'b001, vals[i], pat);
            run_internal(3'b010, vals[i], pat);
            run_ext_in(vals[i], pat);
            run_internal(3'b100, vals[i], pat);
            run_internal(3'b101, vals[i], pat);
            run_internal(3'b110, vals[i], pat);
            run_ext_out(vals[i]);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule